// File: doc/BRIEF.md
# Cartridge Bank Switching Controller

This block translates console CPU and pattern-fetch addresses into cartridge ROM addresses through a small file of eight bank registers. The CPU programs the registers through two decoded write ports in the upper half of its address map. The block then produces a banked program-ROM address for each of four 8 KB CPU windows and a banked pattern address for the 8 KB picture-unit pattern space. The ROM arrays, interrupt counters, mirroring and work RAM sit outside the block.

The register file is kept minimal. Every upper-half write folds onto one of two ports, selected by address bit 0. The layout-mode bits of the select port are discarded, so the program and pattern layouts never change at run time. A build-time parameter chooses how the pattern space is split: mixed 2 KB and 1 KB banks, four uniform 2 KB banks, or the mixed split with bit 6 of every pattern bank number forced, so that each half of the pattern space stays in its own 64 KB region.

Top module: `cartBankCtrl`

## Requirements
- R1: After reset, bank registers B0..B7 are all zero. CPU windows 0 and 1 map to bank 0, and the pattern slots hold the mapping of all-zero registers, visible from the second clock after reset release.
- R2: A write with cpuAddr[15]=0 changes nothing. With cpuAddr[15]=1, only cpuAddr[0] matters: 0 selects the select port and 1 selects the data port.
- R3: A select-port write keeps only cpuData[2:0] as the index of the target register. Bits 7 and 6 have no effect on any mapping.
- R4: A data-port write stores cpuData into the register named by the last select index. The index persists across any number of data writes.
- R5: CPU window w = cpuAddr[14:13] maps to bank B6 (w=0) or B7 (w=1), masked to PRG_BANK_BITS. prgAddr = {bank, cpuAddr[12:0]}, valid from the clock edge that takes the write.
- R6: Window 2 always maps to bank 2^PRG_BANK_BITS-2, and window 3 to bank 2^PRG_BANK_BITS-1.
- R7: In mixed mode (CHR_MODE=0), 1 KB slot s = ppuAddr[12:10] uses {B0[7:1],s[0]} for s=0,1, {B1[7:1],s[0]} for s=2,3, and B(s-2) for s=4..7. Each is masked to CHR_BANK_BITS, and chrAddr = {slot, ppuAddr[9:0]}.
- R8: In uniform mode (CHR_MODE=1), slot s uses {B(2+s/2), s[0]}. B0 and B1 have no effect on the pattern address.
- R9: In forced mode (CHR_MODE=2), the R7 mapping applies after bit 6 of B0 and B1 is cleared and bit 6 of B2..B5 is set.
- R10: The pattern mapping is recomputed on the clock edge after any register-port write, and stays stable otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuWe | input | 1 | CPU write strobe, one cycle per write |
| cpuAddr | input | 16 | CPU address for writes and program lookups |
| cpuData | input | 8 | CPU write data |
| ppuAddr | input | 13 | Pattern-space address |
| prgAddr | output | PRG_BANK_BITS+13 | Banked program-ROM address |
| chrAddr | output | CHR_BANK_BITS+10 | Banked pattern-ROM address |

## Verification
The hardest state to reach is the one-cycle gap between a register update and the pattern-table refresh. In that cycle the program address already shows the new bank while the pattern address still shows the old one. A directed write to B2 is followed by a probe exactly one cycle later and another probe one cycle after that. Folded addresses such as 0xE37E and 0xBFFF, writes below 0x8000, and select values with bits 7 and 6 set are driven directly. Long random write streams across the full 16-bit address space then check all three layout variants in parallel.

// File: rtl/cartBankPkg.sv
package cartBankPkg;
  localparam int CHR_SPLIT  = 0;
  localparam int CHR_QUAD2K = 1;
  localparam int CHR_HIBIT  = 2;

  typedef struct packed {
    logic       selWr;
    logic       dataWr;
    logic       refresh;
    logic [7:0] value;
  } bankStrobeT;
endpackage

// File: rtl/bankCtrlDecode.sv
module bankCtrlDecode
  import cartBankPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuWe,
  input  logic       addrTop,
  input  logic       addrLsb,
  input  logic [7:0] cpuData,
  output bankStrobeT strobe
);
  logic hit;
  logic refreshQ;

  assign hit = cpuWe & addrTop;

  // refresh starts high so the first edge after reset builds the pattern table
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) refreshQ <= 1'b1;
    else       refreshQ <= hit;
  end

  always_comb begin
    strobe.selWr   = hit & ~addrLsb;
    strobe.dataWr  = hit & addrLsb;
    strobe.refresh = refreshQ;
    strobe.value   = cpuData;
  end

  assert_refresh_after_write_R10 : assert property (@(posedge clk) disable iff (!rstN)
    (strobe.selWr || strobe.dataWr) |=> strobe.refresh);
endmodule

// File: rtl/bankRegFile.sv
module bankRegFile
  import cartBankPkg::*;
#(
  parameter int PRG_BANK_BITS = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  bankStrobeT                strobe,
  input  logic [14:0]               cpuAddr,
  output logic [7:0][7:0]           bankQ,
  output logic [PRG_BANK_BITS+12:0] prgAddr
);
  localparam int PB = PRG_BANK_BITS;
  localparam logic [PB-1:0] LAST_BANK = {PB{1'b1}};
  localparam logic [PB-1:0] PENULT_BANK = LAST_BANK - 1'b1;

  logic [2:0]    selQ;
  logic [PB-1:0] bankSel;
  logic          unusedHiBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ  <= '0;
      bankQ <= '0;
    end else begin
      if (strobe.selWr)  selQ <= strobe.value[2:0];
      if (strobe.dataWr) bankQ[selQ] <= strobe.value;
    end
  end

  always_comb begin
    unique case (cpuAddr[14:13])
      2'd0:    bankSel = bankQ[6][PB-1:0];
      2'd1:    bankSel = bankQ[7][PB-1:0];
      2'd2:    bankSel = PENULT_BANK;
      default: bankSel = LAST_BANK;
    endcase
  end

  assign prgAddr = {bankSel, cpuAddr[12:0]};
  assign unusedHiBits = ^{bankQ[6], bankQ[7]};

  assert_sel_capture_R3 : assert property (@(posedge clk) disable iff (!rstN)
    strobe.selWr |=> (selQ == $past(strobe.value[2:0])));
  assert_regs_hold_R4 : assert property (@(posedge clk) disable iff (!rstN)
    !strobe.dataWr |=> $stable(bankQ));
  assert_fixed_window_R6 : assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[14:13] == 2'd2) |-> (prgAddr[PB+12:13] == PENULT_BANK));
endmodule

// File: rtl/chrSlotMap.sv
module chrSlotMap
  import cartBankPkg::*;
#(
  parameter int CHR_BANK_BITS = 7,
  parameter int CHR_MODE      = CHR_SPLIT
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      refresh,
  input  logic [5:0][7:0]           chrRegs,
  input  logic [12:0]               ppuAddr,
  output logic [CHR_BANK_BITS+9:0]  chrAddr
);
  localparam int CB = CHR_BANK_BITS;
  localparam bit FORCE_HI = (CHR_MODE == CHR_HIBIT);

  logic [5:0][7:0]    adj;
  logic [7:0][CB-1:0] slotsNext;
  logic [7:0][CB-1:0] slotQ;

  always_comb begin
    adj = chrRegs;
    if (FORCE_HI) begin
      for (int i = 0; i < 2; i++) adj[i][6] = 1'b0;
      for (int i = 2; i < 6; i++) adj[i][6] = 1'b1;
    end
  end

  generate
    if (CHR_MODE == CHR_QUAD2K) begin : gQuad
      logic unusedLowRegs;
      assign unusedLowRegs = ^{adj[0], adj[1]};
      always_comb begin
        for (int i = 0; i < 4; i++) begin
          slotsNext[2*i]   = CB'({adj[2+i], 1'b0});
          slotsNext[2*i+1] = CB'({adj[2+i], 1'b1});
        end
      end
    end else begin : gSplit
      logic unusedLsb;
      assign unusedLsb = adj[0][0] ^ adj[1][0];
      always_comb begin
        slotsNext[0] = CB'({adj[0][7:1], 1'b0});
        slotsNext[1] = CB'({adj[0][7:1], 1'b1});
        slotsNext[2] = CB'({adj[1][7:1], 1'b0});
        slotsNext[3] = CB'({adj[1][7:1], 1'b1});
        for (int i = 0; i < 4; i++) slotsNext[4+i] = CB'(adj[2+i]);
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        slotQ <= '0;
    else if (refresh) slotQ <= slotsNext;
  end

  assign chrAddr = {slotQ[ppuAddr[12:10]], ppuAddr[9:0]};

  assert_table_hold_R10 : assert property (@(posedge clk) disable iff (!rstN)
    !refresh |=> $stable(slotQ));

  generate
    if (FORCE_HI && CB > 6) begin : gHiChk
      assert_half_region_R9 : assert property (@(posedge clk) disable iff (!rstN)
        !refresh |-> (!slotQ[0][6] && !slotQ[3][6] && slotQ[4][6] && slotQ[7][6]));
    end
  endgenerate
endmodule

// File: rtl/cartBankCtrl.sv
module cartBankCtrl
  import cartBankPkg::*;
#(
  parameter int PRG_BANK_BITS = 4,
  parameter int CHR_BANK_BITS = 7,
  parameter int CHR_MODE      = CHR_SPLIT
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cpuWe,
  input  logic [15:0]               cpuAddr,
  input  logic [7:0]                cpuData,
  input  logic [12:0]               ppuAddr,
  output logic [PRG_BANK_BITS+12:0] prgAddr,
  output logic [CHR_BANK_BITS+9:0]  chrAddr
);
  bankStrobeT      strobe;
  logic [7:0][7:0] bankQ;

  bankCtrlDecode uDecode (
    .clk(clk), .rstN(rstN), .cpuWe(cpuWe),
    .addrTop(cpuAddr[15]), .addrLsb(cpuAddr[0]),
    .cpuData(cpuData), .strobe(strobe)
  );

  bankRegFile #(.PRG_BANK_BITS(PRG_BANK_BITS)) uRegs (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .cpuAddr(cpuAddr[14:0]), .bankQ(bankQ), .prgAddr(prgAddr)
  );

  chrSlotMap #(.CHR_BANK_BITS(CHR_BANK_BITS), .CHR_MODE(CHR_MODE)) uChr (
    .clk(clk), .rstN(rstN), .refresh(strobe.refresh),
    .chrRegs(bankQ[5:0]), .ppuAddr(ppuAddr), .chrAddr(chrAddr)
  );
endmodule

// File: tb/sim_cartBankCtrl.sv
module sim_cartBankCtrl;
  logic        clk = 0;
  logic        rstN = 0;
  logic        cpuWe = 0;
  logic [15:0] cpuAddr = 0;
  logic [7:0]  cpuData = 0;
  logic [12:0] ppuAddr = 0;
  logic [16:0] prg0, prg1, prg2;
  logic [16:0] chr0, chr1, chr2;

  int compared = 0;
  int mismatched = 0;
  logic [7:0] mBank [8];
  int mSel = 0;

  always #5 clk = ~clk;

  cartBankCtrl #(.CHR_MODE(0)) u0 (.clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuData(cpuData), .ppuAddr(ppuAddr), .prgAddr(prg0), .chrAddr(chr0));
  cartBankCtrl #(.CHR_MODE(1)) u1 (.clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuData(cpuData), .ppuAddr(ppuAddr), .prgAddr(prg1), .chrAddr(chr1));
  cartBankCtrl #(.CHR_MODE(2)) u2 (.clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuData(cpuData), .ppuAddr(ppuAddr), .prgAddr(prg2), .chrAddr(chr2));

  function automatic int expPrg(int win, int low);
    int b;
    case (win)
      0: b = mBank[6] & 15;
      1: b = mBank[7] & 15;
      2: b = 14;
      default: b = 15;
    endcase
    return b * 8192 + low;
  endfunction

  function automatic int expChr(int mode, int s, int low);
    int r, u;
    if (mode == 1) begin
      r = mBank[2 + s / 2];
      u = r * 2 + (s % 2);
    end else if (s < 4) begin
      r = mBank[s / 2];
      if (mode == 2) r = r & 8'hBF;
      u = (r & 8'hFE) | (s % 2);
    end else begin
      r = mBank[s - 2];
      if (mode == 2) r = r | 8'h40;
      u = r;
    end
    return (u & 127) * 1024 + low;
  endfunction

  task automatic cmp(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic doWrite(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    cpuWe = 1; cpuAddr = a; cpuData = d;
    @(negedge clk);
    cpuWe = 0;
    if (a[15]) begin
      if (!a[0]) mSel = int'(d[2:0]);
      else       mBank[mSel] = d;
    end
  endtask

  task automatic checkAll(string prgTag);
    repeat (2) @(negedge clk);
    for (int w = 0; w < 4; w++) begin
      int low = int'($urandom % 8192);
      cpuAddr = 16'h8000 | 16'(w << 13) | 16'(low);
      #1;
      cmp(w >= 2 ? "R6" : prgTag, int'(prg0), expPrg(w, low));
      cmp(w >= 2 ? "R6" : prgTag, int'(prg1), expPrg(w, low));
      cmp(w >= 2 ? "R6" : prgTag, int'(prg2), expPrg(w, low));
    end
    for (int s = 0; s < 8; s++) begin
      int low = int'($urandom % 1024);
      ppuAddr = 13'(s * 1024 + low);
      #1;
      cmp("R7", int'(chr0), expChr(0, s, low));
      cmp("R8", int'(chr1), expChr(1, s, low));
      cmp("R9", int'(chr2), expChr(2, s, low));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    int oldChr;
    void'($urandom(32'd4711));
    for (int i = 0; i < 8; i++) mBank[i] = 0;
    repeat (4) @(negedge clk);
    rstN = 1;
    // R1: reset state, windows 0/1 at bank 0, fixed windows, zero-register slots
    checkAll("R1");
    // R3: select with bits 7:6 set still picks B6, layout unchanged; R5 window 0
    doWrite(16'h8000, 8'hC6);
    doWrite(16'h8001, 8'h05);
    checkAll("R5");
    // R2: folded addresses select B7 and write it
    doWrite(16'hE37E, 8'h07);
    doWrite(16'hBFFF, 8'h23);
    checkAll("R2");
    // R2: write below 0x8000 ignored
    doWrite(16'h7FFF, 8'h99);
    doWrite(16'h0001, 8'h44);
    checkAll("R2");
    // R4: index persists, last data wins
    doWrite(16'hA000, 8'h00);
    doWrite(16'hA001, 8'h11);
    doWrite(16'hC001, 8'h7F);
    checkAll("R4");
    // R8/R9 corners: bit 6 patterns in every pattern register
    for (int r = 1; r < 6; r++) begin
      doWrite(16'h8000, 8'(r));
      doWrite(16'h8001, (r % 2) ? 8'hFF : 8'h40);
    end
    checkAll("R3");
    // R10: pattern table lags register update by one edge
    doWrite(16'h8000, 8'h02);
    repeat (2) @(negedge clk);
    ppuAddr = 13'h1000;
    oldChr = expChr(0, 4, 0);
    doWrite(16'h8001, 8'h2A);
    #1;
    cmp("R10", int'(chr0), oldChr);
    @(negedge clk);
    #1;
    cmp("R10", int'(chr0), expChr(0, 4, 0));
    // random streams over the whole address space
    for (int n = 0; n < 600; n++) begin
      doWrite(16'($urandom), 8'($urandom));
      if (n % 25 == 24) checkAll("R5");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule